// File: doc/BRIEF.md
# Routing Requirement Vector Calculator

This unit takes an assignment for a one-sided switching network built from `NSIDE` crossbars around an `NSIDE`-sided switch block. It accepts the assignment as a stream of connection pairs, one per clock. Each endpoint is an external terminal named by a side number and a port number on that side. Side numbers run from 0 to NSIDE-1. Port numbers run from 0 to NPORT-1.

A pair whose two endpoints share a side is counted against that side's crossbar. A pair that spans two sides is counted in the demand vector entry for that unordered side pair. When the final pair arrives, the unit walks the sides one per cycle. For each side it adds up the demand through that face of the switch block and compares the total with the per-side capacity `MCAP`. It then pulses `done_o` and reports an admissible flag and a status code.

Software or a router front end issues `start_i`, streams the pairs, and reads the vector and the status at `done_o`. Choosing the actual paths is left to later logic.

Top module: `rrv_calc`

## Requirements
- R1: After reset, `done_o` is 0, `err_o` is 0, and every vector entry and same-side count is 0.
- R2: A cycle with `start_i` high clears every vector entry, every same-side count, the terminal-in-use record and the status. It opens a new assignment, and any pair offered in that cycle is dropped.
- R3: An accepted pair joining sides i and k (i<k) increments vector entry i*(2*NSIDE-i-1)/2+(k-i-1), whichever endpoint names the lower side. Entry e sits at `rrv_o[e*CW +: CW]`, so entries run (0,1),(0,2)..(0,NSIDE-1),(1,2)..(NSIDE-2,NSIDE-1).
- R4: An accepted pair whose endpoints share side j increments `same_o[j*CW +: CW]` and leaves `rrv_o` unchanged.
- R5: `done_o` is high for exactly one cycle. It rises NSIDE clock edges after the edge that accepts the pair marked last.
- R6: At `done_o`, if no input error was seen and, for every side, the sum of the entries that involve that side is at most MCAP, then `err_o` is 0 and `admissible_o` is 1. If any side exceeds MCAP, `err_o` is 3 (capacity) and `admissible_o` is 0.
- R7: A pair with an endpoint that an earlier accepted pair of the same assignment already used is dropped, and it sets code 1 (repeated terminal).
- R8: A pair whose two endpoints are the same terminal is dropped and sets code 2 (self pair).
- R9: A pair with a side number of NSIDE or more, or a port number of NPORT or more, is dropped and sets code 4 (out of range). The range test has priority over the self test, which has priority over the repeat test.
- R10: The first input error code of an assignment is kept until the next start. Later errors do not replace it, and later legal pairs are still counted.
- R11: Pairs offered outside an open assignment, meaning before any start or after the last pair, change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear and open a new assignment |
| pair_valid_i | input | 1 | A pair is offered this cycle |
| pair_last_i | input | 1 | The offered pair is the final one |
| a_side_i | input | SW | Side of the first endpoint |
| a_port_i | input | PW | Port of the first endpoint |
| b_side_i | input | SW | Side of the second endpoint |
| b_port_i | input | PW | Port of the second endpoint |
| rrv_o | output | NPAIR*CW | Demand vector, one CW-bit entry per side pair |
| same_o | output | NSIDE*CW | Same-side pair count per side |
| done_o | output | 1 | One-cycle completion pulse |
| admissible_o | output | 1 | Status code is 0; meaningful at and after `done_o` |
| err_o | output | 3 | 0 ok, 1 repeated, 2 self, 3 capacity, 4 range |

## Verification
The bench builds the unit with four sides, three ports per side and a capacity of two. Because the capacity is below the port count, a single side can carry more demand than its face allows, so capacity violations can be provoked. Because a three-port field is two bits wide, port number 3 exists and exercises the range error. Six entries and a four-cycle side walk keep exact-capacity, over-capacity and error-priority cases short.

// File: rtl/rrv_pkg.sv
package rrv_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_DUP   = 3'd1,
    ERR_SELF  = 3'd2,
    ERR_CAP   = 3'd3,
    ERR_RANGE = 3'd4
  } rrv_err_e;

  // Slot of unordered side pair (lo, hi), lo < hi, in lexicographic order.
  function automatic int pair_slot(input int lo, input int hi, input int sides);
    return lo * (2 * sides - lo - 1) / 2 + (hi - lo - 1);
  endfunction

endpackage

// File: rtl/rrv_term_map.sv
module rrv_term_map #(
  parameter int NSIDE = 4,
  parameter int NPORT = 2,
  parameter int SW    = 2,
  parameter int PW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          set_en,
  input  logic [SW-1:0] a_side,
  input  logic [PW-1:0] a_port,
  input  logic [SW-1:0] b_side,
  input  logic [PW-1:0] b_port,
  output logic          a_used,
  output logic          b_used
);

  localparam int NTERM = NSIDE * NPORT;
  localparam int TW    = (NTERM > 1) ? $clog2(NTERM) : 1;

  logic [NTERM-1:0] used_q, used_d;
  logic [TW-1:0]    a_ix, b_ix;
  logic             upd;

  assign a_ix   = TW'(int'(a_side) * NPORT + int'(a_port));
  assign b_ix   = TW'(int'(b_side) * NPORT + int'(b_port));
  assign a_used = used_q[a_ix];
  assign b_used = used_q[b_ix];
  assign upd    = clear | set_en;

  always_comb begin
    used_d = used_q;
    if (clear) begin
      used_d = '0;
    end else if (set_en) begin
      used_d[a_ix] = 1'b1;
      used_d[b_ix] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   used_q <= '0;
    else if (upd) used_q <= used_d;
  end

  // R7: both endpoints of an accepted pair are recorded as taken
  p_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clear) |=> (used_q[$past(a_ix)] && used_q[$past(b_ix)]));

endmodule

// File: rtl/rrv_tally.sv
module rrv_tally
  import rrv_pkg::*;
#(
  parameter int NSIDE = 4,
  parameter int SW    = 2,
  parameter int CW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      inc_en,
  input  logic [SW-1:0]             a_side,
  input  logic [SW-1:0]             b_side,
  output logic [NSIDE*(NSIDE-1)/2*CW-1:0] rrv_flat,
  output logic [NSIDE*CW-1:0]       same_flat
);

  localparam int NPAIR = NSIDE * (NSIDE - 1) / 2;
  localparam int SLW   = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [NPAIR-1:0][CW-1:0] rrv_q, rrv_d;
  logic [NSIDE-1:0][CW-1:0] same_q, same_d;
  logic [SW-1:0]            lo, hi;
  logic [SLW-1:0]           slot_ix;
  logic                     upd;

  assign lo        = (a_side < b_side) ? a_side : b_side;
  assign hi        = (a_side < b_side) ? b_side : a_side;
  assign slot_ix   = SLW'(pair_slot(int'(lo), int'(hi), NSIDE));
  assign upd       = clear | inc_en;
  assign rrv_flat  = rrv_q;
  assign same_flat = same_q;

  always_comb begin
    rrv_d  = rrv_q;
    same_d = same_q;
    if (clear) begin
      rrv_d  = '0;
      same_d = '0;
    end else if (inc_en) begin
      if (a_side == b_side) same_d[a_side] = same_q[a_side] + CW'(1);
      else                  rrv_d[slot_ix] = rrv_q[slot_ix] + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrv_q  <= '0;
      same_q <= '0;
    end else if (upd) begin
      rrv_q  <= rrv_d;
      same_q <= same_d;
    end
  end

  int total;
  always_comb begin
    total = 0;
    for (int e = 0; e < NPAIR; e++) total = total + int'(rrv_q[e]);
    for (int j = 0; j < NSIDE; j++) total = total + int'(same_q[j]);
  end

  // R2: clear empties every counter
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (total == 0));
  // R3: one pair adds at most one count
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (total == $past(total) || total == $past(total) + 1));

endmodule

// File: rtl/rrv_side_scan.sv
module rrv_side_scan
  import rrv_pkg::*;
#(
  parameter int NSIDE = 4,
  parameter int SW    = 2,
  parameter int CW    = 3,
  parameter int MCAP  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clear,
  input  logic                            go,
  input  logic [NSIDE*(NSIDE-1)/2*CW-1:0] rrv_flat,
  output logic                            done_o,
  output logic                            over_o
);

  localparam int LW = CW + $clog2(NSIDE);

  logic          busy_q, busy_d;
  logic [SW-1:0] idx_q, idx_d;
  logic          acc_q, acc_d;
  logic          done_q, done_d;
  logic          over_q, over_d;
  logic [LW-1:0] load;
  logic          side_over;

  always_comb begin
    load = '0;
    for (int i = 0; i < NSIDE; i++) begin
      for (int k = i + 1; k < NSIDE; k++) begin
        if (i == int'(idx_q) || k == int'(idx_q))
          load = load + LW'(rrv_flat[pair_slot(i, k, NSIDE)*CW +: CW]);
      end
    end
  end

  assign side_over = (load > LW'(MCAP));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    over_d = over_q;
    done_d = 1'b0;
    if (clear) begin
      busy_d = 1'b0;
      idx_d  = '0;
      acc_d  = 1'b0;
      over_d = 1'b0;
    end else if (go) begin
      busy_d = 1'b1;
      idx_d  = '0;
      acc_d  = 1'b0;
      over_d = 1'b0;
    end else if (busy_q) begin
      acc_d = acc_q | side_over;
      if (int'(idx_q) == NSIDE - 1) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        over_d = acc_q | side_over;
      end else begin
        idx_d = idx_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= 1'b0;
      done_q <= 1'b0;
      over_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      over_q <= over_d;
    end
  end

  assign done_o = done_q;
  assign over_o = over_q;

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5: the walk advances one side per cycle
  p_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !clear && !go && int'(idx_q) != NSIDE - 1)
      |=> (busy_q && idx_q == $past(idx_q) + SW'(1)));

endmodule

// File: rtl/rrv_calc.sv
module rrv_calc
  import rrv_pkg::*;
#(
  parameter int NSIDE = 4,
  parameter int NPORT = 2,
  parameter int MCAP  = 2,
  localparam int SW    = $clog2(NSIDE),
  localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int NPAIR = NSIDE * (NSIDE - 1) / 2,
  localparam int CW    = $clog2(NSIDE * NPORT / 2 + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  pair_valid_i,
  input  logic                  pair_last_i,
  input  logic [SW-1:0]         a_side_i,
  input  logic [PW-1:0]         a_port_i,
  input  logic [SW-1:0]         b_side_i,
  input  logic [PW-1:0]         b_port_i,
  output logic [NPAIR*CW-1:0]   rrv_o,
  output logic [NSIDE*CW-1:0]   same_o,
  output logic                  done_o,
  output logic                  admissible_o,
  output logic [2:0]            err_o
);

  logic     open_q, open_d;
  rrv_err_e err_q, err_d, pair_code, status;
  logic     take, go, pair_ok;
  logic     range_bad, self_bad, dup_bad;
  logic     a_used, b_used, over;

  assign take = open_q & pair_valid_i & ~start_i;
  assign go   = take & pair_last_i;

  assign range_bad = (int'(a_side_i) >= NSIDE) || (int'(b_side_i) >= NSIDE) ||
                     (int'(a_port_i) >= NPORT) || (int'(b_port_i) >= NPORT);
  assign self_bad  = (a_side_i == b_side_i) && (a_port_i == b_port_i);
  assign dup_bad   = a_used | b_used;

  always_comb begin
    if (range_bad)     pair_code = ERR_RANGE;
    else if (self_bad) pair_code = ERR_SELF;
    else if (dup_bad)  pair_code = ERR_DUP;
    else               pair_code = ERR_NONE;
  end

  assign pair_ok = take & (pair_code == ERR_NONE);

  always_comb begin
    open_d = open_q;
    err_d  = err_q;
    if (start_i) begin
      open_d = 1'b1;
      err_d  = ERR_NONE;
    end else if (take) begin
      if (pair_last_i) open_d = 1'b0;
      if (err_q == ERR_NONE && pair_code != ERR_NONE) err_d = pair_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else if (start_i || take) begin
      open_q <= open_d;
      err_q  <= err_d;
    end
  end

  rrv_term_map #(.NSIDE(NSIDE), .NPORT(NPORT), .SW(SW), .PW(PW)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_i),
    .set_en (pair_ok),
    .a_side (a_side_i),
    .a_port (a_port_i),
    .b_side (b_side_i),
    .b_port (b_port_i),
    .a_used (a_used),
    .b_used (b_used)
  );

  rrv_tally #(.NSIDE(NSIDE), .SW(SW), .CW(CW)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_i),
    .inc_en    (pair_ok),
    .a_side    (a_side_i),
    .b_side    (b_side_i),
    .rrv_flat  (rrv_o),
    .same_flat (same_o)
  );

  rrv_side_scan #(.NSIDE(NSIDE), .SW(SW), .CW(CW), .MCAP(MCAP)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_i),
    .go       (go),
    .rrv_flat (rrv_o),
    .done_o   (done_o),
    .over_o   (over)
  );

  assign status       = (err_q != ERR_NONE) ? err_q : (over ? ERR_CAP : ERR_NONE);
  assign err_o        = status;
  assign admissible_o = (status == ERR_NONE);

  // R10: a recorded input error persists until start
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != ERR_NONE && !start_i) |=> (err_q == $past(err_q)));
  // R11: no count moves while no assignment is open
  p_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !start_i) |=> (rrv_o == $past(rrv_o) && same_o == $past(same_o)));
  // R5: no completion right after the last pair
  p_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !done_o);
  // R8: a self pair never passes as accepted
  p_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !range_bad && self_bad) |-> !pair_ok);

endmodule

// File: tb/rrv_calc_tb.sv
`timescale 1ns/1ps
module rrv_calc_tb_top;

  localparam int NS = 4;
  localparam int NP = 3;
  localparam int MC = 2;
  localparam int CWB = 3;
  localparam int NE = 6;
  localparam int NROW = 21;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, pair_valid_i, pair_last_i;
  logic [1:0] a_side_i, a_port_i, b_side_i, b_port_i;
  logic [NE*CWB-1:0] rrv_o;
  logic [NS*CWB-1:0] same_o;
  logic done_o, admissible_o;
  logic [2:0] err_o;

  always #2.5 clk = ~clk;

  rrv_calc #(.NSIDE(NS), .NPORT(NP), .MCAP(MC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_valid_i(pair_valid_i),
    .pair_last_i(pair_last_i), .a_side_i(a_side_i), .a_port_i(a_port_i),
    .b_side_i(b_side_i), .b_port_i(b_port_i), .rrv_o(rrv_o), .same_o(same_o),
    .done_o(done_o), .admissible_o(admissible_o), .err_o(err_o));

  // row: start, as, ap, bs, bp, last, final status
  function automatic logic [12:0] row(input int st, input int as, input int ap,
      input int bs, input int bp, input int ls, input int fe);
    return {1'(st), 2'(as), 2'(ap), 2'(bs), 2'(bp), 1'(ls), 3'(fe)};
  endfunction

  localparam logic [12:0] ROWS [NROW] = '{
    row(1,0,0,1,0,0,0), row(0,2,1,0,1,0,0), row(0,3,2,1,1,0,0), row(0,2,0,2,2,0,0),
    row(0,3,0,3,1,1,0),
    row(1,0,0,1,0,0,0), row(0,0,1,2,0,0,0), row(0,0,2,3,0,1,3),
    row(1,1,3,2,0,0,0), row(0,1,0,1,0,0,0), row(0,1,0,2,0,0,0), row(0,2,0,3,1,0,0),
    row(0,0,0,0,1,1,4),
    row(1,2,2,2,2,0,0), row(0,0,1,3,2,1,2),
    row(1,1,1,0,0,0,0), row(0,1,2,1,1,1,1),
    row(1,0,0,1,0,0,0), row(0,0,1,1,1,0,0), row(0,2,0,3,0,0,0), row(0,2,1,3,1,1,0)
  };

  int errs = 0, checks = 0;
  bit finished = 0;

  int m_rrv [NE];
  int m_same [NS];
  bit m_used [NS*NP];
  int m_err;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_of(input int x, input int y);
    int e = 0;
    for (int i = 0; i < NS; i++)
      for (int k = i + 1; k < NS; k++) begin
        if ((x == i && y == k) || (x == k && y == i)) return e;
        e++;
      end
    return -1;
  endfunction

  function automatic logic [NE*CWB-1:0] pack_rrv();
    logic [NE*CWB-1:0] v = '0;
    for (int e = 0; e < NE; e++) v[e*CWB +: CWB] = CWB'(m_rrv[e]);
    return v;
  endfunction

  function automatic logic [NS*CWB-1:0] pack_same();
    logic [NS*CWB-1:0] v = '0;
    for (int j = 0; j < NS; j++) v[j*CWB +: CWB] = CWB'(m_same[j]);
    return v;
  endfunction

  task automatic model_clear();
    for (int e = 0; e < NE; e++) m_rrv[e] = 0;
    for (int j = 0; j < NS; j++) m_same[j] = 0;
    for (int t = 0; t < NS*NP; t++) m_used[t] = 0;
    m_err = 0;
  endtask

  task automatic model_pair(input int as, input int ap, input int bs, input int bp);
    int code;
    if (as >= NS || bs >= NS || ap >= NP || bp >= NP) code = 4;       // R9
    else if (as == bs && ap == bp) code = 2;                          // R8
    else if (m_used[as*NP+ap] || m_used[bs*NP+bp]) code = 1;          // R7
    else code = 0;
    if (m_err == 0) m_err = code;                                     // R10
    if (code == 0) begin
      m_used[as*NP+ap] = 1;
      m_used[bs*NP+bp] = 1;
      if (as == bs) m_same[as]++;                                     // R4
      else m_rrv[slot_of(as, bs)]++;                                  // R3
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    model_clear();
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 0; pair_valid_i = 0; pair_last_i = 0;
    a_side_i = 0; a_port_i = 0; b_side_i = 0; b_port_i = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(done_o == 0 && err_o == 0, "R1", "done/err after reset", {done_o, err_o}, 0);
    check(rrv_o == 0 && same_o == 0, "R1", "counts after reset", {rrv_o, same_o}, 0);

    // R11: pair before any start is ignored
    @(negedge clk);
    pair_valid_i = 1; a_side_i = 0; a_port_i = 0; b_side_i = 1; b_port_i = 0;
    @(negedge clk);
    pair_valid_i = 0;
    check(rrv_o == 0, "R11", "rrv before start", rrv_o, 0);

    for (int r = 0; r < NROW; r++) begin
      logic [12:0] w;
      int as, ap, bs, bp, fe;
      bit ls;
      w = ROWS[r];
      as = int'(w[11:10]); ap = int'(w[9:8]); bs = int'(w[7:6]); bp = int'(w[5:4]);
      ls = w[3]; fe = int'(w[2:0]);
      if (w[12]) begin
        do_start();
        check(rrv_o == 0 && same_o == 0 && err_o == 0, "R2", "cleared by start",
              {rrv_o, same_o, err_o}, 0);
      end
      @(negedge clk);
      pair_valid_i = 1; pair_last_i = ls;
      a_side_i = 2'(as); a_port_i = 2'(ap); b_side_i = 2'(bs); b_port_i = 2'(bp);
      @(negedge clk);
      pair_valid_i = 0; pair_last_i = 0;
      model_pair(as, ap, bs, bp);
      check(rrv_o == pack_rrv(), "R3", "vector after pair", rrv_o, pack_rrv());
      check(same_o == pack_same(), "R4", "same-side counts", same_o, pack_same());
      check(err_o == 3'(m_err), "R7/R8/R9/R10 code R10", "status after pair",
            err_o, m_err);
      if (ls) begin
        bit timing_ok = (done_o == 0);
        for (int k = 1; k <= NS + 1; k++) begin
          @(negedge clk);
          if (done_o != (k == NS)) timing_ok = 0;
          if (k == NS) begin
            check(err_o == 3'(fe), "R6", "final status", err_o, fe);
            check(admissible_o == (fe == 0), "R6", "admissible", admissible_o, fe == 0);
          end
        end
        check(timing_ok, "R5", "done pulse position", 0, 1);
      end
    end

    // R11: after the last pair, further pairs change nothing
    @(negedge clk);
    pair_valid_i = 1; a_side_i = 0; a_port_i = 2; b_side_i = 1; b_port_i = 2;
    @(negedge clk);
    pair_valid_i = 0;
    check(rrv_o == pack_rrv(), "R11", "vector after close", rrv_o, pack_rrv());

    // R2: start in the same cycle as a pair drops the pair
    @(negedge clk);
    start_i = 1; pair_valid_i = 1; a_side_i = 0; a_port_i = 0; b_side_i = 2; b_port_i = 0;
    @(negedge clk);
    start_i = 0; pair_valid_i = 0;
    model_clear();
    check(rrv_o == 0 && err_o == 0, "R2", "pair with start dropped", rrv_o, 0);

    // R1: reset during an open assignment
    @(negedge clk);
    pair_valid_i = 1; a_side_i = 1; a_port_i = 0; b_side_i = 3; b_port_i = 0;
    @(negedge clk);
    pair_valid_i = 0;
    check(rrv_o != 0, "R3", "pair counted before reset", rrv_o, 1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rrv_o == 0 && done_o == 0 && err_o == 0, "R1", "mid-run reset",
          {rrv_o, done_o, err_o}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule